// File: doc/BRIEF.md
# PS/2 Keyboard Scan-Code Receiver

This block listens to a keyboard on its two open-collector lines, a clock line driven by the keyboard and a data line. Both lines are first brought into the system clock domain through flop synchronizers. The block samples data on each falling edge of the keyboard clock, builds one frame at a time, and checks the start bit, the odd parity and the stop bit. Every accepted byte appears on a raw byte port together with a single-cycle strobe, which can feed an interrupt line directly.

The same byte stream also goes to a small prefix tracker. It folds the release prefix (0xF0) and the extended prefix (0xE0) into flags and reports each finished key as one event. An event carries the code, an extended flag and a released flag, and is marked by its own single-cycle strobe. The keyboard produces autorepeat by resending make codes. Each of those codes is therefore reported as a fresh press.

Top module: `ps2_keyrx`

## Requirements
- R1: After the line synchronizers, data is sampled on falling edges of the keyboard clock. A frame is a 0 start bit, eight data bits sent least significant bit first, a parity bit that makes the count of ones in data plus parity odd, and a 1 stop bit. Its data byte appears on `byte_o`.
- R2: `byte_stb_o` is high for exactly one cycle for each accepted byte, prefix bytes 0xE0 and 0xF0 included, and `byte_o` is valid in that cycle.
- R3: A frame with wrong parity produces no byte strobe and clears any pending prefix.
- R4: A frame whose stop bit is 0 produces no byte strobe and clears any pending prefix.
- R5: A falling edge that finds the data line high while no frame is in progress does not start a frame.
- R6: If no falling edge arrives for `TIMEOUT_CYCLES` system cycles during a frame, the partial frame is discarded and the next start bit begins a new frame.
- R7: A byte other than 0xE0 or 0xF0 that arrives with no pending prefix gives a press event (extended 0, released 0). `key_stb_o` is high for one cycle, in the cycle after that byte's `byte_stb_o`.
- R8: 0xF0 followed by a code gives a release event for that code. Interleaved streams such as 1C 1B F0 1B F0 1C give press 1C, press 1B, release 1B, release 1C.
- R9: 0xE0 followed by a code gives an extended press. 0xE0 0xF0 followed by a code gives an extended release.
- R10: The prefix bytes 0xE0 and 0xF0 never raise `key_stb_o` by themselves.
- R11: Repeated make codes with no break between them each give a separate press event.
- R12: `key_code_o`, `key_ext_o` and `key_rel_o` hold the last event until the next `key_stb_o`.
- R13: During and right after reset, both strobes are low and the byte and key outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kbd_clk_i | input | 1 | Keyboard clock line, asynchronous |
| kbd_data_i | input | 1 | Keyboard data line, asynchronous |
| byte_o | output | 8 | Last accepted raw byte |
| byte_stb_o | output | 1 | One-cycle pulse per accepted byte |
| key_code_o | output | 8 | Key code of the last event |
| key_ext_o | output | 1 | Last event came from an extended key |
| key_rel_o | output | 1 | Last event was a release |
| key_stb_o | output | 1 | One-cycle pulse per key event |

## Verification
The hardest conditions to reach from the ports are a bad frame that lands while a prefix is pending, and a frame abandoned in mid-flight. The driver can corrupt the parity bit or the stop bit of any frame it sends. It places such frames directly after a lone 0xE0 or 0xF0, so the next good code exposes whether the prefix was cleared. For the timeout, the driver stops clocking after a few data bits, holds the clock high for longer than the timeout, and then sends a clean frame. That frame must decode correctly. Any leftover bit from the abandoned frame would corrupt it.

// File: rtl/ps2_keyrx_pkg.sv
package ps2_keyrx_pkg;
   localparam int KEY_W = 8;
   localparam logic [KEY_W-1:0] PFX_EXTENDED = 8'hE0;
   localparam logic [KEY_W-1:0] PFX_RELEASE  = 8'hF0;

   typedef enum logic [1:0] {
      FR_IDLE,
      FR_DATA,
      FR_PARITY,
      FR_STOP
   } frame_st_t;

   typedef struct packed {
      logic [KEY_W-1:0] code;
      logic             ext;
      logic             rel;
   } key_evt_t;
endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
   parameter int   STAGES  = 2,
   parameter logic IDLE_LV = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("ps2_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{IDLE_LV}};
      else        chain_q <= {chain_q[STAGES-2:0], async_i};
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
   import ps2_keyrx_pkg::*;
#(
   parameter int TIMEOUT_CYCLES = 10000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fall_i,
   input  logic             data_i,
   output logic [KEY_W-1:0] byte_o,
   output logic             byte_stb_o,
   output logic             err_stb_o
);
   localparam int BIT_W = $clog2(KEY_W);
   localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(KEY_W - 1);
   localparam logic [CNT_W-1:0] TO_LAST  = CNT_W'(TIMEOUT_CYCLES - 1);

   generate
      if (TIMEOUT_CYCLES < 2) begin : g_bad_timeout
         $error("ps2_frame_rx: TIMEOUT_CYCLES must be at least 2");
      end
   endgenerate

   frame_st_t        st_q;
   logic [BIT_W-1:0] bit_q;
   logic [KEY_W-1:0] shift_q;
   logic             par_q;
   logic [CNT_W-1:0] quiet_q;
   logic             frame_ok;

   // odd parity over data and parity bit, stop bit high
   assign frame_ok = data_i && ((^shift_q) ^ par_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= FR_IDLE;
         bit_q      <= '0;
         shift_q    <= '0;
         par_q      <= 1'b0;
         quiet_q    <= '0;
         byte_o     <= '0;
         byte_stb_o <= 1'b0;
         err_stb_o  <= 1'b0;
      end else begin
         byte_stb_o <= 1'b0;
         err_stb_o  <= 1'b0;
         if (fall_i) begin
            quiet_q <= '0;
            unique case (st_q)
               FR_IDLE: begin
                  if (!data_i) begin
                     st_q  <= FR_DATA;
                     bit_q <= '0;
                  end
               end
               FR_DATA: begin
                  shift_q <= {data_i, shift_q[KEY_W-1:1]};
                  if (bit_q == LAST_BIT) st_q <= FR_PARITY;
                  else                   bit_q <= bit_q + 1'b1;
               end
               FR_PARITY: begin
                  par_q <= data_i;
                  st_q  <= FR_STOP;
               end
               FR_STOP: begin
                  st_q <= FR_IDLE;
                  if (frame_ok) begin
                     byte_o     <= shift_q;
                     byte_stb_o <= 1'b1;
                  end else begin
                     err_stb_o  <= 1'b1;
                  end
               end
               default: st_q <= FR_IDLE;
            endcase
         end else if (st_q != FR_IDLE) begin
            if (quiet_q == TO_LAST) begin
               st_q    <= FR_IDLE;
               quiet_q <= '0;
            end else begin
               quiet_q <= quiet_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/ps2_code_decode.sv
module ps2_code_decode
   import ps2_keyrx_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [KEY_W-1:0] byte_i,
   input  logic             byte_stb_i,
   input  logic             err_stb_i,
   output key_evt_t         evt_o,
   output logic             evt_stb_o
);
   logic ext_pend_q;
   logic rel_pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_pend_q <= 1'b0;
         rel_pend_q <= 1'b0;
         evt_o      <= '0;
         evt_stb_o  <= 1'b0;
      end else begin
         evt_stb_o <= 1'b0;
         if (err_stb_i) begin
            ext_pend_q <= 1'b0;
            rel_pend_q <= 1'b0;
         end else if (byte_stb_i) begin
            if (byte_i == PFX_EXTENDED) begin
               ext_pend_q <= 1'b1;
            end else if (byte_i == PFX_RELEASE) begin
               rel_pend_q <= 1'b1;
            end else begin
               evt_o.code <= byte_i;
               evt_o.ext  <= ext_pend_q;
               evt_o.rel  <= rel_pend_q;
               evt_stb_o  <= 1'b1;
               ext_pend_q <= 1'b0;
               rel_pend_q <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/ps2_keyrx.sv
module ps2_keyrx
   import ps2_keyrx_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter int TIMEOUT_CYCLES = 10000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       kbd_clk_i,
   input  logic       kbd_data_i,
   output logic [7:0] byte_o,
   output logic       byte_stb_o,
   output logic [7:0] key_code_o,
   output logic       key_ext_o,
   output logic       key_rel_o,
   output logic       key_stb_o
);
   generate
      if (KEY_W != 8) begin : g_bad_width
         $error("ps2_keyrx: byte width must be 8");
      end
   endgenerate

   logic     kclk_s, kdat_s, kclk_prev_q, fall;
   logic     err_stb;
   key_evt_t evt;

   ps2_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .async_i(kbd_clk_i), .sync_o(kclk_s));

   ps2_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_sync_dat (
      .clk(clk), .rst_n(rst_n), .async_i(kbd_data_i), .sync_o(kdat_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) kclk_prev_q <= 1'b1;
      else        kclk_prev_q <= kclk_s;
   end

   assign fall = kclk_prev_q & ~kclk_s;

   ps2_frame_rx #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_frame (
      .clk(clk), .rst_n(rst_n), .fall_i(fall), .data_i(kdat_s),
      .byte_o(byte_o), .byte_stb_o(byte_stb_o), .err_stb_o(err_stb));

   ps2_code_decode u_decode (
      .clk(clk), .rst_n(rst_n), .byte_i(byte_o), .byte_stb_i(byte_stb_o),
      .err_stb_i(err_stb), .evt_o(evt), .evt_stb_o(key_stb_o));

   assign key_code_o = evt.code;
   assign key_ext_o  = evt.ext;
   assign key_rel_o  = evt.rel;
endmodule

// File: rtl/ps2_keyrx_chk.sv
module ps2_keyrx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] byte_o,
   input logic       byte_stb_o,
   input logic [7:0] key_code_o,
   input logic       key_ext_o,
   input logic       key_rel_o,
   input logic       key_stb_o
);
   AST_BYTE_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      byte_stb_o |=> !byte_stb_o); // R2
   AST_EVT_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      key_stb_o |-> $past(byte_stb_o)); // R7
   AST_PREFIX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_stb_o && (byte_o == 8'hE0 || byte_o == 8'hF0)) |=> !key_stb_o); // R10
   AST_CODE_GIVES_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_stb_o && byte_o != 8'hE0 && byte_o != 8'hF0)
      |=> (key_stb_o && key_code_o == $past(byte_o))); // R11
   AST_EVT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !key_stb_o |-> ($stable(key_code_o) && $stable(key_ext_o) && $stable(key_rel_o))); // R12
endmodule

bind ps2_keyrx ps2_keyrx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .byte_o(byte_o), .byte_stb_o(byte_stb_o),
   .key_code_o(key_code_o), .key_ext_o(key_ext_o), .key_rel_o(key_rel_o),
   .key_stb_o(key_stb_o));

// File: tb/ps2_keyrx_tb.sv
module ps2_keyrx_tb;
   localparam int TO_CYC = 300;
   localparam int HALF   = 25;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic kclk = 1'b1;
   logic kdat = 1'b1;
   logic [7:0] byte_o, key_code_o;
   logic byte_stb_o, key_ext_o, key_rel_o, key_stb_o;

   always #5 clk = ~clk;

   ps2_keyrx #(.SYNC_STAGES(2), .TIMEOUT_CYCLES(TO_CYC)) u_dut (
      .clk(clk), .rst_n(rst_n), .kbd_clk_i(kclk), .kbd_data_i(kdat),
      .byte_o(byte_o), .byte_stb_o(byte_stb_o), .key_code_o(key_code_o),
      .key_ext_o(key_ext_o), .key_rel_o(key_rel_o), .key_stb_o(key_stb_o));

   typedef struct {
      logic [7:0] code;
      logic       ext;
      logic       rel;
      string      req;
   } exp_evt_t;

   exp_evt_t   evq[$];
   logic [7:0] bq[$];
   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [7:0] last_code = '0;
   logic last_ext = 1'b0, last_rel = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic clk_bit(input logic b);
      kdat = b;
      repeat (HALF) @(posedge clk);
      kclk = 1'b0;
      repeat (HALF) @(posedge clk);
      kclk = 1'b1;
   endtask

   // driver: sends one frame, pushes the expected byte if it should be accepted
   task automatic send(input logic [7:0] b, input bit bad_par, input logic stop_b);
      logic par;
      par = ~(^b) ^ bad_par;
      if (!bad_par && stop_b) bq.push_back(b);
      clk_bit(1'b0);
      for (int i = 0; i < 8; i++) clk_bit(b[i]);
      clk_bit(par);
      clk_bit(stop_b);
      kdat = 1'b1;
      repeat (HALF) @(posedge clk);
   endtask

   task automatic good(input logic [7:0] b);
      send(b, 1'b0, 1'b1);
   endtask

   task automatic expect_evt(input logic [7:0] c, input logic e, input logic r,
                             input string req);
      exp_evt_t x;
      x.code = c; x.ext = e; x.rel = r; x.req = req;
      evq.push_back(x);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (byte_stb_o) begin
            if (bq.size() == 0) chk(1'b0, "R3", "unexpected byte strobe", byte_o, 0);
            else begin
               logic [7:0] eb;
               eb = bq.pop_front();
               chk(byte_o == eb, "R2", "raw byte", byte_o, eb);
            end
            if (!key_stb_o)
               chk({key_code_o, key_ext_o, key_rel_o} == {last_code, last_ext, last_rel},
                   "R12", "held event", {key_code_o, key_ext_o, key_rel_o},
                   {last_code, last_ext, last_rel});
         end
         if (key_stb_o) begin
            if (evq.size() == 0) chk(1'b0, "R10", "unexpected key event", key_code_o, 0);
            else begin
               exp_evt_t x;
               x = evq.pop_front();
               chk({key_code_o, key_ext_o, key_rel_o} == {x.code, x.ext, x.rel}, x.req,
                   "event {code,ext,rel}", {key_code_o, key_ext_o, key_rel_o},
                   {x.code, x.ext, x.rel});
            end
            last_code = key_code_o; last_ext = key_ext_o; last_rel = key_rel_o;
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!byte_stb_o && !key_stb_o && byte_o == 0 && key_code_o == 0 &&
          !key_ext_o && !key_rel_o, "R13", "reset outputs",
          {byte_stb_o, key_stb_o, byte_o, key_code_o}, 0);
      rst_n = 1'b1;
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk(!byte_stb_o && !key_stb_o && key_code_o == 0, "R13", "after reset",
          {byte_stb_o, key_stb_o, key_code_o}, 0);

      // R1 R7: simple press
      expect_evt(8'h1C, 0, 0, "R7"); good(8'h1C);
      // R8: interleaved press/release
      expect_evt(8'h1B, 0, 0, "R8"); expect_evt(8'h1B, 0, 1, "R8");
      expect_evt(8'h1C, 0, 1, "R8");
      good(8'h1B); good(8'hF0); good(8'h1B); good(8'hF0); good(8'h1C);
      // R9: extended press and release
      expect_evt(8'h72, 1, 0, "R9"); expect_evt(8'h72, 1, 1, "R9");
      good(8'hE0); good(8'h72); good(8'hE0); good(8'hF0); good(8'h72);
      // R11: autorepeat
      for (int i = 0; i < 3; i++) expect_evt(8'h1C, 0, 0, "R11");
      for (int i = 0; i < 3; i++) good(8'h1C);
      // R3: bad parity after extended prefix clears it
      expect_evt(8'h1C, 0, 0, "R3");
      good(8'hE0); send(8'h75, 1'b1, 1'b1); good(8'h1C);
      // R4: missing stop after release prefix clears it
      expect_evt(8'h1C, 0, 0, "R4");
      good(8'hF0); send(8'h22, 1'b0, 1'b0); good(8'h1C);
      // R5: falling edge with data high in idle is ignored
      expect_evt(8'h2A, 0, 0, "R5");
      clk_bit(1'b1); kdat = 1'b1; repeat (HALF) @(posedge clk);
      good(8'h2A);
      // R6: partial frame abandoned after quiet period
      expect_evt(8'h15, 0, 0, "R6");
      clk_bit(1'b0); clk_bit(1'b1); clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1);
      kdat = 1'b1;
      repeat (TO_CYC + 60) @(posedge clk);
      good(8'h15);
      // R1: byte with mixed bit pattern, LSB first
      expect_evt(8'hA5, 0, 0, "R1"); good(8'hA5);

      repeat (50) @(posedge clk);
      chk(bq.size() == 0, "R2", "bytes outstanding", bq.size(), 0);
      chk(evq.size() == 0, "R7", "events outstanding", evq.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule